// File: doc/BRIEF.md
# EDAC Mode Controller with Input and Output Latches

This block is the datapath that wraps a single-error-correcting, double-error-detecting codec for a 32-bit memory word that carries a 7-bit check field. A 2-bit mode select picks one of four behaviours:

- **Generate**, for memory writes.
- **Read and flag**, for plain reads.
- **Latch and correct**, which freezes the word, corrects it and presents its syndrome.
- **Diagnostic**, which freezes only the check field while data keeps flowing, so that many data words can be tried against one known check word.

The data and check buses are bidirectional at the chip level. Here each is split into an input, an output and an output enable.

An output data latch captures the corrected word on a rising edge of its latch-enable pin. Four active-low byte enables put single bytes of that latch back on the data bus. The bytes left undriven can be replaced from outside. A return to generate mode then builds a fresh check word from the merged bus before the word is written back.

The input latches are modelled as transparent while their mode lets them pass. They hold the value from the last clock edge of a passing mode. The output latch edge is detected on the block clock.

Top module: `edac_mode_ctrl`

## Requirements
- R1: With mode 2'b00 (generate), chk_o carries the check word of the data bus and chk_oe is high. Both flags (err_n_o, merr_n_o) are high, whatever chk_i holds. Check bit j is the XOR of every data bit i whose column has bit j set. The column of data bit i is the i-th smallest 7-bit value with exactly three ones (bit 0 takes 7'h07, bit 1 takes 7'h0B, and so on).
- R2: With mode 2'b10 (read and flag), both input latches are transparent. A word with no error gives err_n_o=1 and merr_n_o=1 in the same cycle.
- R3: The syndrome is the stored check word XOR the check word computed from the data. A syndrome equal to a data-bit column, or with exactly one bit set, is a single error: err_n_o=0 and merr_n_o=1.
- R4: Any other nonzero syndrome drives both err_n_o and merr_n_o low. This covers even weights, unused weight-3 codes, and weights 5 and 7. merr_n_o is never low while err_n_o is high.
- R5: With mode 2'b11 (latch and correct), both input latches hold the value from the last clock edge before the mode was entered. Changes on data_i and chk_i then have no effect on the flags or the syndrome.
- R6: In mode 2'b11, chk_o carries the syndrome and chk_oe equals the inverse of chk_oe_n_i. In mode 2'b10, chk_oe is always low.
- R7: The output data latch loads the corrected word at the first clock edge where out_le_i is high and was low at the previous edge. At every other edge it keeps its value. The corrected word is the latched data with the bit whose column equals the syndrome inverted.
- R8: data_oe[n] is high exactly when byte_oe_n_i[n] is low, and it drives data_o bits 8n to 8n+7 from the output latch.
- R9: The data path reads the bus as seen at the pins. Each driven byte comes from the output latch and each undriven byte comes from data_i. In mode 2'b00, the new check word is therefore computed over the merged word.
- R10: With mode 2'b01 (diagnostic), the check input latch holds while the data latch stays transparent. The flags compare each new data word against the held check word, and chk_o shows the held check word with chk_oe = ~chk_oe_n_i.
- R11: Synchronous active-high reset clears the output data latch and both held input latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode select: 00 generate, 10 read, 11 correct, 01 diagnostic |
| data_i | input | 32 | Data bus as driven from outside |
| data_o | output | 32 | Output data latch contents |
| data_oe | output | 4 | Per-byte drive enable for data_o |
| chk_i | input | 7 | Check bus as driven from outside |
| chk_o | output | 7 | Generated check word, syndrome or held check word |
| chk_oe | output | 1 | Drive enable for chk_o |
| out_le_i | input | 1 | Output data latch enable, captures on rising level |
| byte_oe_n_i | input | 4 | Active-low per-byte data output enables |
| chk_oe_n_i | input | 1 | Active-low check output enable |
| err_n_o | output | 1 | Active-low error flag |
| merr_n_o | output | 1 | Active-low multiple-error flag |

## Verification
A held latch that wrongly follows its input shows up at once in correct or diagnostic mode. The flags or chk_o then move in the same cycle that garbage appears on data_i or chk_i. A wrong output-latch capture shows on data_o one edge after the rising out_le_i, or as drift on data_o when no edge occurred. A wrong column or merge appears combinationally as a mismatched check word or syndrome on chk_o in the cycle the word is applied.

// File: rtl/edac_pkg.sv
package edac_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int BYTES  = DATA_W / 8;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  chk_t;

    typedef enum logic [1:0] {
        MODE_GEN  = 2'b00,
        MODE_DIAG = 2'b01,
        MODE_READ = 2'b10,
        MODE_CORR = 2'b11
    } mode_e;

    typedef struct packed {
        logic single_n;
        logic multi_n;
    } flags_t;

    typedef struct packed {
        word_t  data;
        chk_t   syn;
        flags_t flags;
    } decode_t;

    // i-th smallest CHK_W-bit value with exactly three ones
    function automatic chk_t column_of(int idx);
        int k;
        k = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(v[CHK_W-1:0]) == 3) begin
                if (k == idx) return chk_t'(v);
                k++;
            end
        end
        return '0;
    endfunction
endpackage

// File: rtl/edac_in_latch.sv
module edac_in_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (pass) held <= d;
    end

    assign q = pass ? d : held;
endmodule

// File: rtl/edac_byte_drive.sv
module edac_byte_drive
    import edac_pkg::*;
(
    input  logic [BYTES-1:0] oe_n,
    input  word_t            lat,
    input  word_t            ext,
    output logic [BYTES-1:0] oe,
    output word_t            bus
);
    for (genvar n = 0; n < BYTES; n++) begin : g_byte
        assign oe[n]          = ~oe_n[n];
        assign bus[8*n +: 8]  = oe[n] ? lat[8*n +: 8] : ext[8*n +: 8];
    end
endmodule

// File: rtl/edac_codec.sv
module edac_codec
    import edac_pkg::*;
(
    input  word_t   data,
    input  chk_t    stored,
    output chk_t    gen,
    output decode_t dec
);
    chk_t        contrib [DATA_W];
    logic [DATA_W-1:0] hit;
    chk_t        syn;

    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam chk_t COL = column_of(i);
        assign contrib[i] = data[i] ? COL : '0;
        assign hit[i]     = (syn == COL);
    end

    always_comb begin
        gen = '0;
        for (int i = 0; i < DATA_W; i++) gen = gen ^ contrib[i];
    end

    assign syn = stored ^ gen;

    always_comb begin
        dec.syn            = syn;
        dec.data           = data ^ hit;
        dec.flags.single_n = (syn == '0);
        dec.flags.multi_n  = (syn == '0) || ($countones(syn) == 1) || (|hit);
    end
endmodule

// File: rtl/edac_mode_ctrl.sv
module edac_mode_ctrl
    import edac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_i,
    input  logic [31:0] data_i,
    output logic [31:0] data_o,
    output logic [3:0]  data_oe,
    input  logic [6:0]  chk_i,
    output logic [6:0]  chk_o,
    output logic        chk_oe,
    input  logic        out_le_i,
    input  logic [3:0]  byte_oe_n_i,
    input  logic        chk_oe_n_i,
    output logic        err_n_o,
    output logic        merr_n_o
);
    mode_e   mode;
    logic    data_pass, chk_pass;
    word_t   bus_data, dlat_q, out_lat;
    chk_t    clat_q, gen_chk;
    decode_t dec;
    logic    le_q;

    assign mode      = mode_e'(mode_i);
    assign data_pass = (mode != MODE_CORR);
    assign chk_pass  = (mode == MODE_GEN) || (mode == MODE_READ);

    edac_byte_drive u_drive (
        .oe_n (byte_oe_n_i),
        .lat  (out_lat),
        .ext  (data_i),
        .oe   (data_oe),
        .bus  (bus_data)
    );

    edac_in_latch #(.W(DATA_W)) u_dlat (
        .clk  (clk),
        .rst  (rst),
        .pass (data_pass),
        .d    (bus_data),
        .q    (dlat_q)
    );

    edac_in_latch #(.W(CHK_W)) u_clat (
        .clk  (clk),
        .rst  (rst),
        .pass (chk_pass),
        .d    (chk_i),
        .q    (clat_q)
    );

    edac_codec u_codec (
        .data   (dlat_q),
        .stored (clat_q),
        .gen    (gen_chk),
        .dec    (dec)
    );

    always_ff @(posedge clk) le_q <= out_le_i;

    always_ff @(posedge clk) begin
        if (rst)                      out_lat <= '0;
        else if (out_le_i && !le_q)   out_lat <= dec.data;
    end

    assign data_o = out_lat;

    always_comb begin
        chk_o    = '0;
        chk_oe   = 1'b0;
        err_n_o  = dec.flags.single_n;
        merr_n_o = dec.flags.multi_n;
        case (mode)
            MODE_GEN: begin
                chk_o    = gen_chk;
                chk_oe   = 1'b1;
                err_n_o  = 1'b1;
                merr_n_o = 1'b1;
            end
            MODE_CORR: begin
                chk_o  = dec.syn;
                chk_oe = ~chk_oe_n_i;
            end
            MODE_DIAG: begin
                chk_o  = clat_q;
                chk_oe = ~chk_oe_n_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/edac_mode_ctrl_sva.sv
module edac_mode_ctrl_sva (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode_i,
    input logic        out_le_i,
    input logic        chk_oe_n_i,
    input logic [31:0] data_o,
    input logic [6:0]  chk_o,
    input logic        chk_oe,
    input logic        err_n_o,
    input logic        merr_n_o
);
    assert_gen_flags_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |-> (chk_oe && err_n_o && merr_n_o));

    assert_flag_order_R4: assert property (@(posedge clk) disable iff (rst)
        !merr_n_o |-> !err_n_o);

    assert_read_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |-> !chk_oe);

    assert_latch_edge_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$rose(out_le_i)) |=> $stable(data_o));

    assert_corr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_i == 2'b11 && $past(mode_i) == 2'b11
         && !chk_oe_n_i && !$past(chk_oe_n_i))
        |-> ($stable(chk_o) && $stable(err_n_o) && $stable(merr_n_o)));

    assert_diag_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode_i == 2'b01 && $past(mode_i) == 2'b01
         && !chk_oe_n_i && !$past(chk_oe_n_i))
        |-> $stable(chk_o));
endmodule

bind edac_mode_ctrl edac_mode_ctrl_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .out_le_i   (out_le_i),
    .chk_oe_n_i (chk_oe_n_i),
    .data_o     (data_o),
    .chk_o      (chk_o),
    .chk_oe     (chk_oe),
    .err_n_o    (err_n_o),
    .merr_n_o   (merr_n_o)
);

// File: tb/edac_mode_ctrl_bench.sv
module edac_mode_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'b10;
    logic [31:0] data_i = '0;
    logic [31:0] data_o;
    logic [3:0]  data_oe;
    logic [6:0]  chk_i = '0;
    logic [6:0]  chk_o;
    logic        chk_oe;
    logic        out_le_i = 1'b0;
    logic [3:0]  byte_oe_n_i = 4'hF;
    logic        chk_oe_n_i = 1'b1;
    logic        err_n_o, merr_n_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [6:0] cols [32];

    always #2 clk = ~clk;

    edac_mode_ctrl u_edac_mode_ctrl (
        .clk(clk), .rst(rst), .mode_i(mode_i), .data_i(data_i),
        .data_o(data_o), .data_oe(data_oe), .chk_i(chk_i), .chk_o(chk_o),
        .chk_oe(chk_oe), .out_le_i(out_le_i), .byte_oe_n_i(byte_oe_n_i),
        .chk_oe_n_i(chk_oe_n_i), .err_n_o(err_n_o), .merr_n_o(merr_n_o)
    );

    // {data, data flip mask, check flip mask}
    localparam logic [70:0] VEC [8] = '{
        {32'h1234_5678, 32'h0000_0000, 7'h00},
        {32'hFFFF_FFFF, 32'h0000_0001, 7'h00},
        {32'h0000_0000, 32'h8000_0000, 7'h00},
        {32'hA5A5_5A5A, 32'h0000_0000, 7'h40},
        {32'hDEAD_BEEF, 32'h0010_0008, 7'h00},
        {32'h0F0F_F0F0, 32'h0000_0200, 7'h04},
        {32'h1357_9BDF, 32'h0000_0000, 7'h03},
        {32'h2468_ACE0, 32'h0000_0007, 7'h00}
    };

    function automatic logic [6:0] bgen(logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= cols[i];
        return c;
    endfunction

    function automatic logic [1:0] bflags(logic [6:0] s);
        if (s == 0) return 2'b11;
        if ($countones(s) == 1) return 2'b01;
        for (int i = 0; i < 32; i++) if (s == cols[i]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] bfix(logic [31:0] d, logic [6:0] s);
        logic [31:0] r = d;
        for (int i = 0; i < 32; i++) if (s == cols[i]) r[i] = ~r[i];
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k = 0;
        for (int c = 2; c < 7; c++)
            for (int b = 1; b < c; b++)
                for (int a = 0; a < b; a++) begin
                    if (k < 32) cols[k] = 7'((1 << c) | (1 << b) | (1 << a));
                    k++;
                end

        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R11: reset clears output latch; zero word reads clean
        check("R11 data_o", 64'(data_o), 64'h0);
        check("R11 flags", 64'({err_n_o, merr_n_o}), 64'h3);

        // Table-driven read / correct / capture
        for (int v = 0; v < 8; v++) begin
            logic [31:0] d, df;
            logic [6:0]  cf, syn;
            logic [1:0]  fl;
            d  = VEC[v][70:39];
            df = VEC[v][38:7];
            cf = VEC[v][6:0];
            syn = (bgen(d) ^ cf) ^ bgen(d ^ df);
            fl  = bflags(syn);
            mode_i = 2'b10; byte_oe_n_i = 4'hF; chk_oe_n_i = 1'b1; out_le_i = 1'b0;
            data_i = d ^ df; chk_i = bgen(d) ^ cf;
            #1;
            check("R2 R3 R4 read flags", 64'({err_n_o, merr_n_o}), 64'(fl));
            check("R6 read no check drive", 64'(chk_oe), 64'h0);
            tick();
            mode_i = 2'b11; chk_oe_n_i = 1'b0;
            data_i = ~data_i; chk_i = ~chk_i;
            #1;
            check("R6 syndrome", 64'({chk_oe, chk_o}), 64'({1'b1, syn}));
            check("R5 held flags", 64'({err_n_o, merr_n_o}), 64'(fl));
            out_le_i = 1'b1;
            tick();
            check("R7 corrected capture", 64'(data_o), 64'(bfix(d ^ df, syn)));
        end

        // R6: correct mode with check enable high
        chk_oe_n_i = 1'b1;
        #1;
        check("R6 oe off in correct", 64'(chk_oe), 64'h0);

        // R1: generate mode ignores chk_i, flags high
        mode_i = 2'b00; data_i = 32'hCAFE_F00D; chk_i = 7'h7F; out_le_i = 1'b0;
        #1;
        check("R1 generated word", 64'({chk_oe, chk_o}), 64'({1'b1, bgen(32'hCAFE_F00D)}));
        check("R1 flags high", 64'({err_n_o, merr_n_o}), 64'h3);

        // R8: byte enables
        byte_oe_n_i = 4'b1010;
        #1;
        check("R8 byte oe", 64'(data_oe), 64'h5);
        byte_oe_n_i = 4'hF;

        // R9: read-modify-write merge
        mode_i = 2'b10; data_i = 32'h89AB_CDEF; chk_i = bgen(32'h89AB_CDEF);
        tick();
        mode_i = 2'b11;
        tick();
        out_le_i = 1'b1;
        tick();
        check("R7 rmw capture", 64'(data_o), 64'h89AB_CDEF);
        tick();
        check("R7 no recapture while high", 64'(data_o), 64'h89AB_CDEF);
        byte_oe_n_i = 4'b1100; mode_i = 2'b00; data_i = 32'h5566_7788;
        #1;
        check("R8 rmw drive", 64'(data_oe), 64'h3);
        check("R9 merged check", 64'(chk_o), 64'(bgen(32'h5566_CDEF)));

        // R10: diagnostic mode against a fixed check word
        byte_oe_n_i = 4'hF; out_le_i = 1'b0;
        mode_i = 2'b10; data_i = 32'h0BAD_F00D; chk_i = bgen(32'h0BAD_F00D);
        tick();
        mode_i = 2'b01; chk_i = 7'h55; chk_oe_n_i = 1'b0;
        #1;
        check("R10 held check out", 64'({chk_oe, chk_o}), 64'({1'b1, bgen(32'h0BAD_F00D)}));
        check("R10 clean data", 64'({err_n_o, merr_n_o}), 64'h3);
        tick();
        data_i = 32'h0BAD_F00D ^ 32'h20;
        #1;
        check("R10 single vs held", 64'({err_n_o, merr_n_o}), 64'h1);
        tick();
        data_i = 32'h0BAD_F00D ^ 32'h60;
        #1;
        check("R10 double vs held", 64'({err_n_o, merr_n_o}), 64'h0);
        check("R10 check still held", 64'(chk_o), 64'(bgen(32'h0BAD_F00D)));

        // R4: unused weight-3 syndrome is uncorrectable
        mode_i = 2'b10; data_i = 32'h0; chk_i = 7'h70;
        #1;
        check("R4 unused column", 64'({err_n_o, merr_n_o}), 64'h0);

        // R11: reset clears output latch
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        check("R11 latch cleared", 64'(data_o), 64'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule